// File: doc/BRIEF.md
# Stereo Sum-Difference Decoder

The block turns a pair of signed channel samples into a left/right pair. One input carries the sum of the two sound channels and the other carries their difference. A third input gives the measured strength of the difference channel. If that strength is high enough, the block forms the sum and the difference of the two inputs, each halved with an arithmetic shift, and presents them as the two decoded outputs. If the strength is weak, the difference channel is too noisy to use, so the first input is copied to both outputs and the result is mono.

Samples arrive with a valid flag and no back-pressure. Each accepted sample leaves one clock later, together with a delayed copy of the flag. Between samples the registered outputs keep their last value. The sum and the difference are formed one bit wider than the samples before the shift, so no input pair can overflow.

Top module: `stereo_matrix_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, out_valid is 0 and out_a and out_b are 0.
- R2: out_valid equals the in_valid that was sampled on the previous rising clock edge.
- R3: When in_strength is less than the threshold (default 25), both out_a and out_b equal in_a one cycle after the sample.
- R4: When in_strength is at least the threshold, out_a equals (in_a + in_b) shifted right by one, one cycle after the sample.
- R5: When in_strength is at least the threshold, out_b equals (in_a - in_b) shifted right by one, one cycle after the sample.
- R6: The shift is arithmetic, so odd results round toward minus infinity (for example -7 gives -4, and 1 gives 0).
- R7: in_strength is compared as a two's-complement signed number: 24 and any negative value select mono, and 25 and the largest positive value select stereo.
- R8: The sum and the difference are formed one bit wider than the samples, so the extreme sample values give exact halved results with no wrap.
- R9: On a cycle with in_valid low, out_a and out_b keep their previous values whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is presented this cycle |
| in_a | input | SAMPLE_W (32) | First (sum) channel sample, two's complement |
| in_b | input | SAMPLE_W (32) | Second (difference) channel sample, two's complement |
| in_strength | input | STRENGTH_W (32) | Strength of the difference channel, signed |
| out_valid | output | 1 | The decoded pair is new this cycle |
| out_a | output | SAMPLE_W (32) | First decoded output |
| out_b | output | SAMPLE_W (32) | Second decoded output |

## Verification
A wrong route choice or a wrong arithmetic result appears in out_a and out_b on the cycle right after the sample, so each error is seen in the same cycle it is made. A wrong sign extension or a dropped carry bit only shows up with large values or opposite-sign values. For that reason the extreme and mixed-sign pairs are driven on their own, next to the threshold values 24 and 25 and the negative strengths. A hold register that updates on an idle cycle shows up as a changed output while out_valid is low, so idle cycles carry nonzero data.

// File: rtl/stereo_dec_pkg.sv
package stereo_dec_pkg;

    localparam int DEF_SAMPLE_W   = 32;
    localparam int DEF_STRENGTH_W = 32;
    localparam int DEF_THRESHOLD  = 25;

    typedef enum logic {
        ROUTE_MONO   = 1'b0,
        ROUTE_STEREO = 1'b1
    } route_e;

endpackage

// File: rtl/sdd_strength_gate.sv
module sdd_strength_gate
    import stereo_dec_pkg::*;
#(
    parameter int STRENGTH_W = DEF_STRENGTH_W,
    parameter int THRESHOLD  = DEF_THRESHOLD
) (
    input  logic [STRENGTH_W-1:0] strength,
    output route_e                route
);
    localparam logic signed [STRENGTH_W-1:0] THR = STRENGTH_W'(THRESHOLD);

    always_comb begin
        if ($signed(strength) < THR) route = ROUTE_MONO;
        else                         route = ROUTE_STEREO;
    end
endmodule

// File: rtl/sdd_matrix.sv
module sdd_matrix #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chk_en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] half_sum,
    output logic [W-1:0] half_diff
);
    localparam int WX = W + 1;

    logic signed [WX-1:0] a_x, b_x, sum_x, diff_x;

    always_comb begin
        a_x    = {a[W-1], a};
        b_x    = {b[W-1], b};
        sum_x  = a_x + b_x;
        diff_x = a_x - b_x;
        half_sum  = sum_x[WX-1:1];
        half_diff = diff_x[WX-1:1];
    end

    // R8: the halved sum always lies between the two inputs
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (($signed(half_sum) >= $signed(a) || $signed(half_sum) >= $signed(b)) &&
                    ($signed(half_sum) <= $signed(a) || $signed(half_sum) <= $signed(b))));

    // R5: the halved difference is non-negative exactly when a >= b
    p_diff_sign_r5: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (($signed(a) >= $signed(b)) == !half_diff[W-1]));
endmodule

// File: rtl/sdd_out_stage.sv
module sdd_out_stage
    import stereo_dec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  route_e       route,
    input  logic [W-1:0] mono_src,
    input  logic [W-1:0] half_sum,
    input  logic [W-1:0] half_diff,
    output logic         out_valid,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b
);
    logic [W-1:0] nxt_a, nxt_b;

    always_comb begin
        unique case (route)
            ROUTE_MONO:   begin nxt_a = mono_src; nxt_b = mono_src;  end
            ROUTE_STEREO: begin nxt_a = half_sum; nxt_b = half_diff; end
            default:      begin nxt_a = mono_src; nxt_b = mono_src;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_a <= nxt_a;
                out_b <= nxt_b;
            end
        end
    end

    // R2: the flag comes out one cycle late
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_delay_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: idle cycles leave the data registers alone
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_a) && $stable(out_b)));
endmodule

// File: rtl/stereo_matrix_decoder.sv
module stereo_matrix_decoder
    import stereo_dec_pkg::*;
#(
    parameter int SAMPLE_W   = DEF_SAMPLE_W,
    parameter int STRENGTH_W = DEF_STRENGTH_W,
    parameter int THRESHOLD  = DEF_THRESHOLD
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [SAMPLE_W-1:0]   in_a,
    input  logic [SAMPLE_W-1:0]   in_b,
    input  logic [STRENGTH_W-1:0] in_strength,
    output logic                  out_valid,
    output logic [SAMPLE_W-1:0]   out_a,
    output logic [SAMPLE_W-1:0]   out_b
);
    localparam logic signed [STRENGTH_W-1:0] THR_S = STRENGTH_W'(THRESHOLD);

    route_e              route;
    logic [SAMPLE_W-1:0] half_sum, half_diff;

    sdd_strength_gate #(.STRENGTH_W(STRENGTH_W), .THRESHOLD(THRESHOLD)) u_gate (
        .strength (in_strength),
        .route    (route)
    );

    sdd_matrix #(.W(SAMPLE_W)) u_matrix (
        .clk       (clk),
        .rst       (rst),
        .chk_en    (in_valid),
        .a         (in_a),
        .b         (in_b),
        .half_sum  (half_sum),
        .half_diff (half_diff)
    );

    sdd_out_stage #(.W(SAMPLE_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .route     (route),
        .mono_src  (in_a),
        .half_sum  (half_sum),
        .half_diff (half_diff),
        .out_valid (out_valid),
        .out_a     (out_a),
        .out_b     (out_b)
    );

    // R3: a weak sample copies the first input to both outputs
    p_mono_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ($signed(in_strength) < THR_S)) |=>
            (out_a == $past(in_a) && out_b == $past(in_a)));

    // R1: the cycle after reset shows an idle, cleared output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_a == '0 && out_b == '0));
endmodule

// File: tb/tb_stereo_matrix_decoder.sv
module tb_stereo_matrix_decoder;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0, in_strength = '0;
    logic         out_valid;
    logic [W-1:0] out_a, out_b;

    stereo_matrix_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_strength(in_strength), .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state: what the outputs must show after the next edge
    bit           exp_v = 0;
    logic [W-1:0] exp_a = '0, exp_b = '0;
    string        exp_tag_a = "R1", exp_tag_b = "R1";

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, $signed(act), $signed(exp));
        end
    endtask

    function automatic logic [W-1:0] halve(input longint v);
        longint h;
        h = v >>> 1;
        return h[W-1:0];
    endfunction

    // apply one input at the negedge, update the model, check after the next posedge
    task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] s, input string ta, input string tb);
        longint la, lb, ls;
        in_valid = v; in_a = a; in_b = b; in_strength = s;
        la = longint'($signed(a)); lb = longint'($signed(b)); ls = longint'($signed(s));
        exp_v = v;
        if (v) begin
            if (ls < 25) begin exp_a = a; exp_b = a; end
            else begin exp_a = halve(la + lb); exp_b = halve(la - lb); end
            exp_tag_a = ta; exp_tag_b = tb;
        end else begin
            exp_tag_a = "R9"; exp_tag_b = "R9";
        end
        @(negedge clk);
        check("R2", {31'd0, out_valid}, {31'd0, exp_v}, "out_valid");
        check(exp_tag_a, out_a, exp_a, "out_a");
        check(exp_tag_b, out_b, exp_b, "out_b");
    endtask

    localparam logic [W-1:0] MAXV = 32'h7fff_ffff;
    localparam logic [W-1:0] MINV = 32'h8000_0000;

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        in_a = 32'd77; in_b = 32'd5; in_strength = 32'd99;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1", {31'd0, out_valid}, '0, "out_valid in reset");
        check("R1", out_a, '0, "out_a in reset");
        check("R1", out_b, '0, "out_b in reset");
        rst = 1'b0;
        step(0, 32'd11, 32'd12, 32'd50, "R1", "R1");
        check("R1", out_a, '0, "out_a after reset");

        step(1, 32'd100, 32'd50, 32'd24, "R3", "R3");
        step(1, 32'd100, 32'd50, 32'd25, "R4", "R5");
        step(1, 32'd7, 32'd0, 32'd1000, "R4", "R5");
        step(1, -32'sd7, 32'd0, 32'd30, "R6", "R6");
        step(1, -32'sd3, 32'd4, 32'd99, "R6", "R6");
        step(1, 32'd5, 32'd9, 32'hffff_ffff, "R7", "R7");
        step(1, 32'd5, 32'd9, MINV, "R7", "R7");
        step(1, 32'd5, 32'd9, MAXV, "R7", "R7");
        step(1, MAXV, MAXV, 32'd50, "R8", "R8");
        step(1, MINV, MINV, 32'd50, "R8", "R8");
        step(1, MAXV, MINV, 32'd50, "R8", "R8");
        step(1, MINV, MAXV, 32'd50, "R8", "R8");
        // R9: idle cycles with live-looking data
        step(0, 32'd1234, 32'd99, 32'd10, "R9", "R9");
        step(0, 32'd42, 32'd7, 32'd500, "R9", "R9");
        step(1, 32'd42, 32'd7, 32'd10, "R3", "R3");
        step(0, 32'd9, 32'd8, 32'd500, "R9", "R9");

        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb, rs;
            bit rv;
            ra = $urandom; rb = $urandom;
            rs = (i % 3 == 0) ? 32'($urandom_range(0, 50)) - 32'd5 : $urandom;
            rv = ($urandom_range(0, 3) != 0);
            step(rv, ra, rb, rs, "R4", "R5");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule